// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Status

This peripheral holds two independent down-counting timers and one shared interrupt status block. Software reaches it through a plain 32-bit register bus. The bus carries an address, a write strobe and write data. Read data is combinational from the current address. Each timer has three registers: a limit register, a count register that reads the live value, and a control register. The control register both chooses a count rate and issues a command: load, run or stop.

Count rates are tick enables taken from the system clock. Rate code 4 ticks every `TICK_SLOW` clocks and rate code 5 every `TICK_FAST` clocks. When a running timer counts through 1, it raises its pending bit and reloads itself.

Pending bits are sticky. A mask register gates them onto one level interrupt line. A write-one-to-clear acknowledge register retires them. A free-running cycle counter, a watchdog control word that is accepted and ignored, and a zero-returning default for unmapped offsets complete the map.

Top module: `twin_timer_regs`

## Requirements
- R1: After reset the raw status (0x50), mask (0x48), and both count registers (0x04 timer 0, 0x14 timer 1) read 0, and `irq_o` is low.
- R2: A control write with command bits [1:0] = 0 loads the count and the reload value from the limit register (0x00 timer 0, 0x10 timer 1), and stops the timer. A limit up to 2048 loads unchanged. A limit above 2048 loads limit >> 3.
- R3: Command 1 starts counting and command 2 stops it. While stopped, the count holds. While running with rate field bits [6:4] = 4, the count drops by one every `TICK_SLOW` clocks. With rate 5, it drops every `TICK_FAST` clocks. The first decrement lands that many clocks after the command edge.
- R4: With rate code 0 or 1, a running timer does not count.
- R5: A tick on a count of 1 sets raw status bit 0 for timer 0 or bit 1 for timer 1, and reloads the count. The bit stays set until acknowledged, so the timer expires periodically.
- R6: `irq_o` is high exactly when some raw bit is also set in the mask. It rises in the same cycle that the raw or mask bit becomes set.
- R7: Offset 0x54 reads raw status AND mask. Offset 0x50 reads raw status. Offset 0x48 reads the mask.
- R8: Writing 0x4C clears every raw bit written as 1 and leaves the other bits alone. `irq_o` falls only when no masked pending bit remains.
- R9: If an expiry and an acknowledge of the same bit fall in one cycle, the bit stays set.
- R10: Writes to the watchdog word at 0x40 change no readable register and no timer state.
- R11: Offset 0x38 returns a counter that advances by one on every clock and wraps modulo 2^32.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt, OR of masked pending bits |

## Verification
The checker covers several rules on every cycle:
- the cycle counter steps by one each clock;
- a pending bit survives until it is acknowledged;
- an expiry beats a same-cycle acknowledge;
- an acknowledge without a colliding expiry clears its bit;
- a stopped timer holds its count;
- the masked status read agrees with the interrupt line;
- a watchdog write leaves the mask and the run state untouched.

Only the directed scenarios can show the rest:
- the exact load values on both sides of the 2048 limit;
- the tick spacing of each rate code;
- the exact expiry cycle and the periodic reload;
- the idle behaviour of rate codes 0 and 1;
- the interrupt staying high while one masked bit remains after a partial acknowledge.

// File: rtl/twin_timer_regs.sv
module twin_timer_regs #(
  parameter int AW           = 8,
  parameter int TICK_SLOW    = 3,
  parameter int TICK_FAST    = 2,
  parameter int LIMIT_THRESH = 2048,
  parameter int PRE_SHIFT    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o
);
  localparam int TMAX = (TICK_SLOW > TICK_FAST) ? TICK_SLOW : TICK_FAST;
  localparam int DIVW = $clog2(TMAX) + 1;

  logic [1:0][31:0] cnt_v, lim_v;
  logic [1:0]       run_v, expire;
  logic [1:0]       raw_q, mask_q;
  logic [31:0]      time_q;

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    localparam logic [AW-1:0] BASE = AW'(t * 16);
    logic [31:0]     limit_q, cnt_q, rel_q;
    logic [2:0]      sel_q;
    logic            run_q;
    logic [DIVW-1:0] div_q, period;
    logic [31:0]     ld;
    logic            wr_lim, wr_ctl, tick;

    assign wr_lim = bus_we && bus_addr == BASE;
    assign wr_ctl = bus_we && bus_addr == BASE + AW'(8);

    always_comb begin
      case (sel_q)
        3'd4:    period = DIVW'(TICK_SLOW);
        3'd5:    period = DIVW'(TICK_FAST);
        default: period = '0;
      endcase
    end

    assign tick      = run_q && period != '0 && div_q == period - 1'b1;
    assign expire[t] = tick && cnt_q == 32'd1;
    assign ld        = (limit_q > 32'(LIMIT_THRESH)) ? (limit_q >> PRE_SHIFT) : limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        limit_q <= '0;
        cnt_q   <= '0;
        rel_q   <= '0;
        sel_q   <= '0;
        run_q   <= 1'b0;
        div_q   <= '0;
      end else begin
        if (wr_lim) limit_q <= bus_wdata;
        if (wr_ctl) begin
          sel_q <= bus_wdata[6:4];
          div_q <= '0;
          case (bus_wdata[1:0])
            2'd0: begin
              cnt_q <= ld;
              rel_q <= ld;
              run_q <= 1'b0;
            end
            2'd1:    run_q <= 1'b1;
            2'd2:    run_q <= 1'b0;
            default: ;
          endcase
        end else if (run_q && period != '0) begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick && cnt_q != '0)
            cnt_q <= (cnt_q == 32'd1) ? rel_q : cnt_q - 32'd1;
        end
      end
    end

    assign cnt_v[t] = cnt_q;
    assign lim_v[t] = limit_q;
    assign run_v[t] = run_q;
  end

  logic ack_wr, mask_wr;
  assign ack_wr  = bus_we && bus_addr == AW'('h4C);
  assign mask_wr = bus_we && bus_addr == AW'('h48);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      time_q <= '0;
    end else begin
      time_q <= time_q + 32'd1;
      if (mask_wr) mask_q <= bus_wdata[1:0];
      raw_q <= (raw_q & ~(ack_wr ? bus_wdata[1:0] : 2'b00)) | expire;
    end
  end

  assign irq_o = |(raw_q & mask_q);

  always_comb begin
    case (bus_addr)
      AW'('h00): bus_rdata = lim_v[0];
      AW'('h04): bus_rdata = cnt_v[0];
      AW'('h10): bus_rdata = lim_v[1];
      AW'('h14): bus_rdata = cnt_v[1];
      AW'('h38): bus_rdata = time_q;
      AW'('h48): bus_rdata = {30'd0, mask_q};
      AW'('h50): bus_rdata = {30'd0, raw_q};
      AW'('h54): bus_rdata = {30'd0, raw_q & mask_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

module twin_timer_regs_chk #(
  parameter int AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq_o,
  input logic [1:0]       raw_q,
  input logic [1:0]       mask_q,
  input logic [1:0]       expire,
  input logic [1:0]       run_v,
  input logic [1:0][31:0] cnt_v,
  input logic [31:0]      time_q
);
  logic ack0, ack1, ctl0_wr, ctl1_wr, wd_wr;
  assign ack0    = bus_we && bus_addr == AW'('h4C) && bus_wdata[0];
  assign ack1    = bus_we && bus_addr == AW'('h4C) && bus_wdata[1];
  assign ctl0_wr = bus_we && bus_addr == AW'('h08);
  assign ctl1_wr = bus_we && bus_addr == AW'('h18);
  assign wd_wr   = bus_we && bus_addr == AW'('h40);

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> time_q == $past(time_q) + 32'd1); // R11
  AST_RAW0_STICKY: assert property (@(posedge clk) disable iff (!rst_n) raw_q[0] && !ack0 |=> raw_q[0]); // R5
  AST_RAW1_STICKY: assert property (@(posedge clk) disable iff (!rst_n) raw_q[1] && !ack1 |=> raw_q[1]); // R5
  AST_EXPIRY0_WINS: assert property (@(posedge clk) disable iff (!rst_n) expire[0] |=> raw_q[0]); // R9
  AST_EXPIRY1_WINS: assert property (@(posedge clk) disable iff (!rst_n) expire[1] |=> raw_q[1]); // R9
  AST_ACK0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ack0 && !expire[0] |=> !raw_q[0]); // R8
  AST_ACK1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ack1 && !expire[1] |=> !raw_q[1]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) raw_q == 2'b00 |-> !irq_o); // R6
  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n) bus_addr == AW'('h54) |-> (bus_rdata != 32'd0) == irq_o); // R7
  AST_STOP0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !run_v[0] && !ctl0_wr |=> $stable(cnt_v[0])); // R3
  AST_STOP1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !run_v[1] && !ctl1_wr |=> $stable(cnt_v[1])); // R3
  AST_WD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) wd_wr |=> $stable(mask_q) && $stable(run_v)); // R10
endmodule

bind twin_timer_regs twin_timer_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .raw_q(raw_q), .mask_q(mask_q), .expire(expire), .run_v(run_v),
  .cnt_v(cnt_v), .time_q(time_q)
);

// File: tb/test_twin_timer_regs.sv
module test_twin_timer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  twin_timer_regs i_twin_timer_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rdchk("R1 raw", 8'h50, 0);
    rdchk("R1 mask", 8'h48, 0);
    rdchk("R1 cnt0", 8'h04, 0);
    rdchk("R1 cnt1", 8'h14, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    rdchk("R12 unmapped 0x7C", 8'h7C, 0);
    rdchk("R12 unmapped 0x24", 8'h24, 0);
  endtask

  task automatic t_load;
    wr(8'h00, 100);  wr(8'h08, 32'h40);
    rdchk("R2 load small", 8'h04, 100);
    wr(8'h10, 5000); wr(8'h18, 32'h40);
    rdchk("R2 load prescaled", 8'h14, 625);
    wr(8'h00, 2048); wr(8'h08, 32'h40);
    rdchk("R2 limit 2048 boundary", 8'h04, 2048);
    wr(8'h00, 2049); wr(8'h08, 32'h40);
    rdchk("R2 limit 2049 boundary", 8'h04, 256);
  endtask

  task automatic t_clock_off;
    wr(8'h00, 5); wr(8'h08, 32'h00);
    wr(8'h08, 32'h01);
    cyc(20);
    rdchk("R4 rate code 0 idle", 8'h04, 5);
    wr(8'h08, 32'h11);
    cyc(20);
    rdchk("R4 rate code 1 idle", 8'h04, 5);
    wr(8'h08, 32'h12);
    rdchk("R4 no pending", 8'h50, 0);
  endtask

  task automatic t_slow_expiry;
    wr(8'h00, 4); wr(8'h08, 32'h40);
    wr(8'h08, 32'h41);
    cyc(3);
    rdchk("R3 first slow tick", 8'h04, 3);
    cyc(8);
    rdchk("R3 count before expiry", 8'h04, 1);
    rdchk("R5 not yet expired", 8'h50, 0);
    cyc(1);
    rdchk("R5 raw bit0 set", 8'h50, 1);
    rdchk("R5 reloaded", 8'h04, 4);
    chk("R6 irq masked off", {31'd0, irq_o}, 0);
    rdchk("R7 masked read zero", 8'h54, 0);
    wr(8'h48, 1);
    chk("R6 irq after mask", {31'd0, irq_o}, 1);
    rdchk("R7 masked read", 8'h54, 1);
    rdchk("R7 mask read", 8'h48, 1);
    wr(8'h08, 32'h42);
    cyc(10);
    rdchk("R3 stop holds", 8'h04, 4);
  endtask

  task automatic t_fast_ack;
    wr(8'h10, 3); wr(8'h18, 32'h50);
    wr(8'h18, 32'h51);
    cyc(5);
    rdchk("R3 fast before expiry", 8'h50, 1);
    cyc(1);
    rdchk("R5 timer1 bit1", 8'h50, 3);
    wr(8'h18, 32'h52);
    wr(8'h48, 3);
    wr(8'h4C, 1);
    rdchk("R8 partial ack", 8'h50, 2);
    chk("R8 irq stays high", {31'd0, irq_o}, 1);
    wr(8'h4C, 2);
    rdchk("R8 full ack", 8'h50, 0);
    chk("R8 irq drops", {31'd0, irq_o}, 0);
  endtask

  task automatic t_same_cycle;
    wr(8'h00, 2); wr(8'h08, 32'h50);
    wr(8'h08, 32'h51);
    cyc(3);
    wr(8'h4C, 1);
    rdchk("R9 expiry beats ack", 8'h50, 1);
    chk("R9 irq", {31'd0, irq_o}, 1);
    wr(8'h4C, 1);
    rdchk("R8 ack clears", 8'h50, 0);
    cyc(2);
    rdchk("R5 periodic not yet", 8'h50, 0);
    cyc(1);
    rdchk("R5 periodic reexpiry", 8'h50, 1);
    wr(8'h08, 32'h52);
  endtask

  task automatic t_watchdog;
    logic [31:0] m, r, c;
    rd(8'h48, m); rd(8'h50, r); rd(8'h04, c);
    wr(8'h40, 32'hFFFF_FFFF);
    cyc(4);
    rdchk("R10 mask kept", 8'h48, m);
    rdchk("R10 raw kept", 8'h50, r);
    rdchk("R10 count kept", 8'h04, c);
  endtask

  task automatic t_time;
    logic [31:0] a, b;
    rd(8'h38, a);
    cyc(7);
    rd(8'h38, b);
    chk("R11 cycle counter", b, a + 32'd7);
  endtask

  initial begin
    fork
      begin
        #35 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_load();
        t_clock_off();
        t_slow_expiry();
        t_fast_ack();
        t_same_cycle();
        t_watchdog();
        t_time();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule